// File: doc/BRIEF.md
# Dual-Threshold Time-Over-Threshold Hit Recorder

This block turns the discriminator outputs of a group of strip channels into timestamped hit records. Each channel supplies two comparator bits. One compares against a low readout threshold. The other compares against a higher qualifying threshold. Both bits are asynchronous to the block. They pass through a two-flop synchronizer and are then sampled once per frame, and the frame number serves as the event time. A rising edge on the low bit opens a candidate window for that channel. The window is accepted only if the high bit is seen while the window is open. When the low bit falls, an accepted window produces one record. The record holds the channel index, the frame in which the pulse started and the frame in which it ended. The distance between the two timestamps is the time over threshold, so pulse height is captured as it happens and no analog buffering is needed.

A single fast clock runs the whole block. One frame lasts `NUM_CH` fast cycles, so with eight channels and a 50 ns clock the frame period is 400 ns. Every channel owns one slot per frame, and in that slot its window logic is evaluated and its record is written. This merges all channel streams onto one FIFO write port without arbitration. The reader drains the FIFO through a valid/ready handshake. If records arrive while the FIFO is full, they are lost, and a sticky flag reports the loss.

Top module: `tot_hit_recorder`

## Requirements
- R1: While reset is asserted, and at the end of it, `outValid` and `overflow` are low.
- R2: A channel whose low bit is sampled high in frames F to G-1 and low in frame G, and whose high bit is sampled high in at least one of those open frames, produces exactly one record. The record word is {channel index, F mod 2^TS_W, G mod 2^TS_W}: the channel index in the top CH_W bits, the leading timestamp in the middle TS_W bits and the trailing timestamp in the low TS_W bits.
- R3: A window whose low bit falls without the high bit having been sampled high while it was open produces no record.
- R4: A high bit that is asserted while the channel's low bit is low produces no record.
- R5: A high-bit sample counts toward qualification in any open frame: the opening frame, a middle frame or the last high frame. A high sample in the closing frame, where the low bit is already low, does not count.
- R6: The frame counter wraps modulo 2^TS_W. A window that spans the wrap keeps its original leading timestamp, so the trailing timestamp may be numerically smaller.
- R7: Records from windows that close in the same frame leave the FIFO in ascending channel order. The FIFO keeps the order of arrival.
- R8: A record that finds the FIFO full is dropped and sets `overflow`, which stays set. The records already in the FIFO are unchanged.
- R9: A one-cycle pulse on `clrOvf` clears `overflow` in the next cycle.
- R10: While `outValid` is high and `outReady` is low, `outValid` stays high and `outWord` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock. One frame is NUM_CH cycles. |
| rstN | input | 1 | Asynchronous reset, active low. |
| compLo | input | NUM_CH | Low-threshold comparator bits, one per channel, asynchronous. |
| compHi | input | NUM_CH | High-threshold comparator bits, one per channel, asynchronous. |
| clrOvf | input | 1 | Clears the overflow flag. |
| outValid | output | 1 | The FIFO head record is valid. |
| outReady | input | 1 | The reader accepts the head record. |
| outWord | output | CH_W+2*TS_W | Head record {channel, leading time, trailing time}. |
| overflow | output | 1 | Sticky flag: at least one record was dropped. |

## Verification
The bench builds the block with eight channels, a 5-bit timestamp and a 4-entry FIFO. The short timestamp brings the counter wrap within 32 frames, so a window that straddles the wrap can be exercised in a short run. The small FIFO lets one frame of eight simultaneous closings overflow it while the reader stalls. The bench sweeps every channel with the qualifying sample placed in each position of an open window. It also drives negative patterns (no qualifier, a qualifier only in the closing sample, a qualifier with no window). It predicts every record from the frame numbers it drove.

// File: rtl/tot_pkg.sv
package tot_pkg;

  // Strobes issued by the frame sequencer to the hit datapath.
  typedef struct packed {
    logic snapTake;  // last slot of a frame: capture comparators and frame time
    logic evalEn;    // a valid snapshot exists, per-slot evaluation allowed
  } totStrobe_t;

endpackage

// File: rtl/tot_sync2.sv
module tot_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/tot_ctrl.sv
module tot_ctrl #(
  parameter int NUM_CH = 8,
  parameter int TS_W   = 13,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  output tot_pkg::totStrobe_t strobe,
  output logic [CH_W-1:0]     slotIdx,
  output logic [TS_W-1:0]     tsCount
);

  localparam logic [CH_W-1:0] LAST_SLOT = CH_W'(NUM_CH - 1);

  logic primed;
  logic frameEnd;

  assign frameEnd = (slotIdx == LAST_SLOT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotIdx <= '0;
      tsCount <= '0;
      primed  <= 1'b0;
    end else if (frameEnd) begin
      slotIdx <= '0;
      tsCount <= tsCount + 1'b1;
      primed  <= 1'b1;
    end else begin
      slotIdx <= slotIdx + 1'b1;
    end
  end

  always_comb begin
    strobe.snapTake = frameEnd;
    strobe.evalEn   = primed;
  end

  // R6: the frame time advances by one, modulo its width, once per frame
  a_r6_ts_step: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> tsCount == TS_W'($past(tsCount) + 1'b1));

  // R7: slots are visited in ascending order inside a frame
  a_r7_slot_order: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> slotIdx == CH_W'($past(slotIdx) + 1'b1));

endmodule

// File: rtl/tot_datapath.sv
module tot_datapath #(
  parameter int NUM_CH = 8,
  parameter int TS_W   = 13,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int WORD_W = CH_W + 2 * TS_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  tot_pkg::totStrobe_t strobe,
  input  logic [CH_W-1:0]     slotIdx,
  input  logic [TS_W-1:0]     tsCount,
  input  logic [NUM_CH-1:0]   compLo,
  input  logic [NUM_CH-1:0]   compHi,
  input  logic                clrOvf,
  input  logic                fifoFull,
  output logic                pushEn,
  output logic [WORD_W-1:0]   pushWord,
  output logic                overflow
);

  logic [NUM_CH-1:0] loSynced, hiSynced;
  logic [NUM_CH-1:0] snapLo, snapHi;
  logic [TS_W-1:0]   snapTs;
  logic [NUM_CH-1:0] winOpen, winQual;
  logic [TS_W-1:0]   leadTs [NUM_CH];

  logic curLo, curHi, curOpen, curQual;
  logic closing, emitHit, dropHit;

  tot_sync2 #(.W(NUM_CH)) u_syncLo (.clk(clk), .rstN(rstN), .d(compLo), .q(loSynced));
  tot_sync2 #(.W(NUM_CH)) u_syncHi (.clk(clk), .rstN(rstN), .d(compHi), .q(hiSynced));

  // Frame snapshot: all channels sampled at one instant, tagged with the frame time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapLo <= '0;
      snapHi <= '0;
      snapTs <= '0;
    end else if (strobe.snapTake) begin
      snapLo <= loSynced;
      snapHi <= hiSynced;
      snapTs <= tsCount;
    end
  end

  // Per-channel window state, updated only in the channel's own slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winOpen <= '0;
      winQual <= '0;
      for (int c = 0; c < NUM_CH; c++) leadTs[c] <= '0;
    end else if (strobe.evalEn) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (slotIdx == CH_W'(c)) begin
          winOpen[c] <= snapLo[c];
          if (snapLo[c] && !winOpen[c]) begin
            leadTs[c]  <= snapTs;
            winQual[c] <= snapHi[c];
          end else if (snapLo[c]) begin
            winQual[c] <= winQual[c] | snapHi[c];
          end else begin
            winQual[c] <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    curLo    = snapLo[slotIdx];
    curHi    = snapHi[slotIdx];
    curOpen  = winOpen[slotIdx];
    curQual  = winQual[slotIdx];
    closing  = strobe.evalEn && curOpen && !curLo;
    emitHit  = closing && curQual;
    pushEn   = emitHit && !fifoFull;
    dropHit  = emitHit && fifoFull;
    pushWord = {slotIdx, leadTs[slotIdx], snapTs};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        overflow <= 1'b0;
    else if (clrOvf)  overflow <= 1'b0;
    else if (dropHit) overflow <= 1'b1;
  end

  // R8: a dropped record raises the flag
  a_r8_drop_sets: assert property (@(posedge clk) disable iff (!rstN)
    dropHit && !clrOvf |=> overflow);

  // R8: the flag is sticky until cleared
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !clrOvf |=> overflow);

  // R9: clearing takes effect in the next cycle
  a_r9_ovf_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrOvf |=> !overflow);

  // R5: a closing sample's high bit never opens a record on its own
  a_r5_close_needs_prior: assert property (@(posedge clk) disable iff (!rstN)
    (closing && curHi && !curQual) |-> !pushEn);

endmodule

// File: rtl/tot_fifo.sv
module tot_fifo #(
  parameter int W     = 29,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  output logic         full,
  output logic         rdValid,
  input  logic         rdReady,
  output logic [W-1:0] rdData
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doRd;

  assign full    = (count == CW'(DEPTH));
  assign rdValid = (count != '0);
  assign rdData  = mem[rdPtr];
  assign doRd    = rdValid && rdReady;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({wrEn, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: the datapath never writes into a full queue
  a_r8_no_write_full: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !full);

  // R10: a stalled head record stays valid and unchanged
  a_r10_hold_head: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid && $stable(rdData));

endmodule

// File: rtl/tot_hit_recorder.sv
module tot_hit_recorder #(
  parameter int NUM_CH     = 8,
  parameter int TS_W       = 13,
  parameter int FIFO_DEPTH = 16,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int WORD_W    = CH_W + 2 * TS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] compLo,
  input  logic [NUM_CH-1:0] compHi,
  input  logic              clrOvf,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outWord,
  output logic              overflow
);

  tot_pkg::totStrobe_t strobe;
  logic [CH_W-1:0]   slotIdx;
  logic [TS_W-1:0]   tsCount;
  logic              pushEn, fifoFull;
  logic [WORD_W-1:0] pushWord;

  tot_ctrl #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx), .tsCount(tsCount)
  );

  tot_datapath #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx), .tsCount(tsCount),
    .compLo(compLo), .compHi(compHi), .clrOvf(clrOvf), .fifoFull(fifoFull),
    .pushEn(pushEn), .pushWord(pushWord), .overflow(overflow)
  );

  tot_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .wrEn(pushEn), .wrData(pushWord), .full(fifoFull),
    .rdValid(outValid), .rdReady(outReady), .rdData(outWord)
  );

endmodule

// File: tb/tot_hit_recorder_bench.sv
`timescale 1ns/1ps
module tot_hit_recorder_bench;

  localparam int CLK_PERIOD = 50;
  localparam int NUM_CH = 8;
  localparam int TS_W   = 5;
  localparam int DEPTH  = 4;
  localparam int CH_W   = 3;
  localparam int WW     = CH_W + 2 * TS_W;
  localparam int TS_MOD = 1 << TS_W;

  logic clk = 1'b0;
  logic rstN;
  logic [NUM_CH-1:0] compLo, compHi;
  logic clrOvf, outValid, outReady, overflow;
  logic [WW-1:0] outWord;

  int cyc;
  int nChecks = 0;
  int nFail = 0;
  logic [WW-1:0] recWord [64];
  int nRec = 0;
  logic [WW-1:0] expWord [64];
  string expTag [64];
  int nExp = 0;
  bit done = 0;

  tot_hit_recorder #(.NUM_CH(NUM_CH), .TS_W(TS_W), .FIFO_DEPTH(DEPTH)) u_tot_hit_recorder (
    .clk(clk), .rstN(rstN), .compLo(compLo), .compHi(compHi), .clrOvf(clrOvf),
    .outValid(outValid), .outReady(outReady), .outWord(outWord), .overflow(overflow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  // Record every handshake, sampled a quarter period after the falling edge
  always begin
    @(negedge clk);
    #(CLK_PERIOD / 4);
    if (rstN && outValid && outReady && nRec < 64) begin
      recWord[nRec] = outWord;
      nRec++;
    end
  end

  function automatic logic [WW-1:0] mkWord(input int ch, input int lead, input int trail);
    return {CH_W'(ch), TS_W'(lead % TS_MOD), TS_W'(trail % TS_MOD)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectHit(input int ch, input int lead, input int trail, input string tag);
    expWord[nExp] = mkWord(ch, lead, trail);
    expTag[nExp]  = tag;
    nExp++;
  endtask

  // Wait until slot 2 of frame f (one frame = NUM_CH cycles)
  task automatic atFrame(input int f);
    while (cyc < NUM_CH * f + 2) @(negedge clk);
  endtask

  task automatic drive(input int f, input logic [NUM_CH-1:0] lo, input logic [NUM_CH-1:0] hi);
    atFrame(f);
    compLo = lo;
    compHi = hi;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [NUM_CH-1:0] hiVec;
    rstN = 1'b0; compLo = '0; compHi = '0; clrOvf = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset
    check(outValid == 1'b0, "R1 valid in reset", 32'(outValid), 0);
    check(overflow == 1'b0, "R1 overflow in reset", 32'(overflow), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && overflow == 1'b0, "R1 after reset", {outValid, overflow}, 0);

    // R2/R5: all channels open in frame 2, close in frame 5; each channel
    // sees its high bit in opening, middle or last open frame (c mod 3)
    for (int f = 2; f <= 4; f++) begin
      for (int c = 0; c < NUM_CH; c++) hiVec[c] = ((c % 3) == (f - 2));
      drive(f, '1, hiVec);
    end
    drive(5, '0, '0);
    for (int c = 0; c < NUM_CH; c++) expectHit(c, 2, 5, "R2/R5/R7 sweep");

    // R3 and R5: window with the high bit only in the closing sample
    drive(8, 8'h0F, 8'h00);
    drive(9, 8'h00, 8'h0F);
    drive(10, 8'h00, 8'h00);
    atFrame(12);
    check(nRec == 8, "R3 no record without qualifier", 32'(nRec), 8);

    // R4: high bit with no open window
    drive(13, 8'h00, 8'hF0);
    drive(14, 8'h00, 8'h00);
    atFrame(16);
    check(nRec == 8, "R4 qualifier alone ignored", 32'(nRec), 8);

    // R6: channel 5 spans the counter wrap; R7: channel 1 closes in the same frame
    drive(30, 8'h20, 8'h00);
    drive(31, 8'h20, 8'h20);
    drive(32, 8'h20, 8'h00);
    drive(33, 8'h22, 8'h02);
    drive(34, 8'h00, 8'h00);
    expectHit(1, 33, 34, "R7 order");
    expectHit(5, 30, 34, "R6 wrap");

    // R8: stall the reader, close eight windows at once into a 4-entry FIFO
    atFrame(36);
    outReady = 1'b0;
    drive(37, '1, '1);
    drive(38, '0, '0);
    for (int c = 0; c < DEPTH; c++) expectHit(c, 37, 38, "R8 kept entries");
    atFrame(40);
    check(overflow == 1'b1, "R8 overflow set", 32'(overflow), 1);
    check(outValid == 1'b1 && outWord == mkWord(0, 37, 38), "R10 head while stalled",
          32'(outWord), 32'(mkWord(0, 37, 38)));
    atFrame(41);
    check(outValid == 1'b1 && outWord == mkWord(0, 37, 38), "R10 head held",
          32'(outWord), 32'(mkWord(0, 37, 38)));
    outReady = 1'b1;
    atFrame(43);
    check(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 1);
    check(outValid == 1'b0, "R8 only FIFO depth kept", 32'(outValid), 0);

    // R9: clear pulse
    atFrame(44);
    clrOvf = 1'b1;
    @(negedge clk);
    clrOvf = 1'b0;
    atFrame(45);
    check(overflow == 1'b0, "R9 overflow cleared", 32'(overflow), 0);

    // Compare the recorded stream with the predicted one (R2, R6, R7, R8)
    check(nRec == nExp, "R2 record count", 32'(nRec), 32'(nExp));
    for (int i = 0; i < nExp && i < nRec; i++)
      check(recWord[i] == expWord[i], expTag[i], 32'(recWord[i]), 32'(expWord[i]));

    finishRun();
  end

endmodule